// File: doc/BRIEF.md
# Four-Link Byte-Interleaved Serial Bus Multiplexer

This block merges the 2.048 Mb/s mapped frames of four links onto one serial data line and one matching signaling line, both running at 8.192 Mb/s. Each 125 µs frame on the bus holds 128 byte slots. Each link gets a 2-bit channel offset, and that offset decides which slot positions inside every group of four carry the link's bytes. A shared bus clock and frame pulse time all four links. A second copy of the block serves the next four links.

The block samples the bus clock level (`bclk`) in its own `clk` domain and turns the chosen edges into enables. `clk` must therefore see every bus clock level for at least one cycle. Configuration selects:
- which bus clock edge samples the frame pulse and which edge launches data;
- whether the bus clock runs at the bit rate or at twice the bit rate, and in the double-rate case which edge of each pair is used;
- the polarity of the frame pulse;
- a bit offset between the frame pulse and the start of the frame.

The per-link frame buffers stay outside the block. On every launch tick the block drives a link number and a timeslot number. It takes the addressed data byte and signaling nibble back in the same cycle, as a combinational lookup. The serial outputs are timed only by the frame pulse and the bus clock, so there is no valid/ready handshake and no back-pressure: the buffer port must answer on every launch tick.

Top module: `bmux_quad`

## Requirements
- R1: Frame bit b (0..1023) lies in slot s = b/8 and carries bit 7-(b mod 8) of a byte, so the most significant bit goes first. Slot s carries the link whose 2-bit offset field (link l at `link_offset[2l+1:2l]`) equals s mod 4, taking that link's timeslot s/4 through `rd_link`/`rd_slot`.
- R2: When two or more links hold the same offset, `offset_clash` is high and the lowest-numbered of them owns the slots.
- R3: A slot whose residue no link's offset matches drives ones on both `ser_data` and `ser_sig`.
- R4: In each slot, bit times 0-3 of `ser_sig` are ones and bit times 4-7 carry `rd_sig[3]` down to `rd_sig[0]`.
- R5: The frame pulse is active high when `fp_active_low` is 0 and active low when it is 1. A pulse counts on the first sampling edge at which it is active.
- R6: `fp_fall`=1 samples the frame pulse on falling `bclk` edges and 0 on rising edges. `data_fall` picks the launch edge the same way. The first launch edge strictly after the sampling edge that caught the pulse begins the frame.
- R7: With `clk2x`=1, launch edges pair up counting from that first edge. `second_edge`=0 launches on the first edge of each pair and 1 on the second. With `clk2x`=0, every launch edge launches.
- R8: The launch tick that begins the frame outputs frame bit (1024-`bit_offset`) mod 1024, so frame bit 0 appears `bit_offset` ticks later.
- R9: Before the first frame pulse both outputs are ones. The outputs change only on launch ticks.
- R10: If a frame pulse begins a frame a number of launch ticks after the previous one that is not a multiple of 1024, `fp_period_err` rises and stays high until reset. `irq` is `fp_period_err` AND `irq_en`.
- R11: After reset `ser_data` and `ser_sig` are 1, and `fp_period_err` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, at least twice the bus clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Bus clock level, synchronous to clk |
| fp_in | input | 1 | Frame pulse |
| fp_active_low | input | 1 | 1: frame pulse active low |
| fp_fall | input | 1 | 1: sample frame pulse on falling bclk edge |
| data_fall | input | 1 | 1: launch outputs on falling bclk edge |
| clk2x | input | 1 | 1: bclk runs at twice the bit rate |
| second_edge | input | 1 | In double rate, 1 launches on second edge of each pair |
| bit_offset | input | 10 | Bit offset of frame start after the pulse |
| link_offset | input | 8 | Four 2-bit channel offsets, link 0 in bits 1:0 |
| irq_en | input | 1 | Enables irq from the period error |
| rd_link | output | 2 | Frame buffer lookup: link |
| rd_slot | output | 5 | Frame buffer lookup: timeslot |
| rd_byte | input | 8 | Looked-up data byte |
| rd_sig | input | 4 | Looked-up signaling nibble |
| ser_data | output | 1 | Serial data bus |
| ser_sig | output | 1 | Serial signaling bus |
| offset_clash | output | 1 | Two links share an offset |
| fp_period_err | output | 1 | Sticky frame pulse spacing error |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume four things about the inputs:
- `bclk` holds each level for at least one `clk` cycle and only starts toggling once reset has been released with it low.
- Every configuration input is static while frames run.
- A frame pulse is active at exactly one sampling edge.
- The buffer lookup answers in the same cycle.

The stimulus keeps within these limits. Each bus clock level lasts exactly one `clk`. Configuration changes only while reset is held. Each pulse is held for one full bus clock period, so it covers a single sampling edge. The lookup is a combinational read of bench arrays filled from `$urandom`.

// File: rtl/bmux_pkg.sv
package bmux_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} bus_edge_e;

  function automatic logic edge_hit(bus_edge_e sel, logic rise, logic fall);
    return (sel == EDGE_FALL) ? fall : rise;
  endfunction
endpackage

// File: rtl/bmux_edge_timer.sv
module bmux_edge_timer
  import bmux_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fp_in,
  input  logic fp_active_low,
  input  logic fp_fall,
  input  logic data_fall,
  input  logic clk2x,
  input  logic second_edge,
  output logic tick,
  output logic start
);
  logic bclk_q, fp_seen, fp_pend, defer, half;
  logic rise, fall, ev_f, ev_d, fp_act, fp_det, h;

  assign rise   = bclk & ~bclk_q;
  assign fall   = ~bclk & bclk_q;
  assign ev_f   = edge_hit(bus_edge_e'(fp_fall), rise, fall);
  assign ev_d   = edge_hit(bus_edge_e'(data_fall), rise, fall);
  assign fp_act = fp_in ^ fp_active_low;
  assign fp_det = ev_f & fp_act & ~fp_seen;
  // pair phase restarts at the first launch edge after a pulse
  assign h      = fp_pend ? 1'b0 : half;
  assign tick   = ev_d & (~clk2x | (h == second_edge));
  assign start  = tick & (fp_pend | defer);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      fp_seen <= 1'b0;
      fp_pend <= 1'b0;
      defer   <= 1'b0;
      half    <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (ev_f) fp_seen <= fp_act;
      if (ev_d) begin
        half    <= ~h;
        fp_pend <= 1'b0;
        if (tick)         defer <= 1'b0;
        else if (fp_pend) defer <= 1'b1;
      end
      if (fp_det) fp_pend <= 1'b1;
    end
  end

  // R6: launch ticks only fall on the selected bclk edge
  p_launch_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (data_fall ? (!bclk && $past(bclk)) : (bclk && !$past(bclk))));
endmodule

// File: rtl/bmux_frame_counter.sv
module bmux_frame_counter #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [IDX_W-1:0] bit_offset,
  output logic [IDX_W-1:0] nidx,
  output logic             locked,
  output logic             period_err
);
  logic [IDX_W-1:0] idx, ph;

  assign nidx = start ? (IDX_W'(0) - bit_offset) : (idx + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx        <= '0;
      ph         <= '0;
      locked     <= 1'b0;
      period_err <= 1'b0;
    end else if (tick) begin
      idx <= nidx;
      if (start) begin
        if (locked && ph != '0) period_err <= 1'b1;
        ph     <= IDX_W'(1);
        locked <= 1'b1;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  // R10: the error is sticky
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    period_err |=> period_err);
  // R10: the error only rises when a pulse begins a frame
  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(period_err) |-> $past(start));
endmodule

// File: rtl/bmux_slot_mapper.sv
module bmux_slot_mapper #(
  parameter int LINKS = 4,
  localparam int LW = $clog2(LINKS)
) (
  input  logic [LINKS*LW-1:0] link_offset,
  input  logic [LW-1:0]       residue,
  output logic [LW-1:0]       owner,
  output logic                owned,
  output logic                clash
);
  logic [LINKS-1:0] hit;
  logic [LINKS-1:0] dup;

  for (genvar l = 0; l < LINKS; l++) begin : g_hit
    assign hit[l] = (link_offset[l*LW +: LW] == residue);
    if (l == 0) begin : g_first
      assign dup[l] = 1'b0;
    end else begin : g_rest
      logic [l-1:0] same;
      for (genvar m = 0; m < l; m++) begin : g_cmp
        assign same[m] = (link_offset[l*LW +: LW] == link_offset[m*LW +: LW]);
      end
      assign dup[l] = |same;
    end
  end

  // lowest-numbered matching link wins
  always_comb begin
    owned = 1'b0;
    owner = '0;
    for (int l = LINKS - 1; l >= 0; l--) begin
      if (hit[l]) begin
        owned = 1'b1;
        owner = LW'(l);
      end
    end
  end

  assign clash = |dup;
endmodule

// File: rtl/bmux_quad.sv
module bmux_quad #(
  parameter int LINKS  = 4,
  parameter int SLOTS  = 128,
  parameter int BYTE_W = 8,
  localparam int LW    = $clog2(LINKS),
  localparam int SIG_W = BYTE_W / 2,
  localparam int BW_W  = $clog2(BYTE_W),
  localparam int SW_W  = $clog2(SIG_W),
  localparam int IDX_W = $clog2(SLOTS * BYTE_W),
  localparam int TS_W  = IDX_W - BW_W - LW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                fp_in,
  input  logic                fp_active_low,
  input  logic                fp_fall,
  input  logic                data_fall,
  input  logic                clk2x,
  input  logic                second_edge,
  input  logic [IDX_W-1:0]    bit_offset,
  input  logic [LINKS*LW-1:0] link_offset,
  input  logic                irq_en,
  output logic [LW-1:0]       rd_link,
  output logic [TS_W-1:0]     rd_slot,
  input  logic [BYTE_W-1:0]   rd_byte,
  input  logic [SIG_W-1:0]    rd_sig,
  output logic                ser_data,
  output logic                ser_sig,
  output logic                offset_clash,
  output logic                fp_period_err,
  output logic                irq
);
  logic tick, start, locked, owned;
  logic [IDX_W-1:0] nidx;
  logic [BW_W-1:0]  bitpos;
  logic [LW-1:0]    residue;

  bmux_edge_timer u_timer (
    .clk, .rst_n, .bclk, .fp_in, .fp_active_low, .fp_fall, .data_fall,
    .clk2x, .second_edge, .tick, .start
  );

  bmux_frame_counter #(.IDX_W(IDX_W)) u_count (
    .clk, .rst_n, .tick, .start, .bit_offset, .nidx, .locked,
    .period_err(fp_period_err)
  );

  assign bitpos  = nidx[BW_W-1:0];
  assign residue = nidx[BW_W +: LW];
  assign rd_slot = nidx[IDX_W-1 -: TS_W];

  bmux_slot_mapper #(.LINKS(LINKS)) u_map (
    .link_offset, .residue, .owner(rd_link), .owned, .clash(offset_clash)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_data <= 1'b1;
      ser_sig  <= 1'b1;
    end else if (tick) begin
      if ((locked | start) & owned) begin
        ser_data <= rd_byte[~bitpos];
        ser_sig  <= bitpos[BW_W-1] ? rd_sig[~bitpos[SW_W-1:0]] : 1'b1;
      end else begin
        ser_data <= 1'b1;
        ser_sig  <= 1'b1;
      end
    end
  end

  assign irq = fp_period_err & irq_en;

  // R9: idle bus before the first frame
  p_idle_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (ser_data && ser_sig));
  // R9: outputs move only on launch ticks
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(ser_data) && $stable(ser_sig)));
  // R4: first half of each slot pads the signaling bus with ones
  p_sig_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bitpos[BW_W-1]) |=> ser_sig);
  // R3: unowned slots drive ones
  p_no_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !owned) |=> (ser_data && ser_sig));
endmodule

// File: tb/bmux_quad_tb_top.sv
module bmux_quad_tb_top;
  localparam int FB = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic bclk = 1'b0, fp_in = 1'b0, fp_active_low = 1'b0, fp_fall = 1'b0;
  logic data_fall = 1'b0, clk2x = 1'b0, second_edge = 1'b0, irq_en = 1'b0;
  logic [9:0] bit_offset = '0;
  logic [7:0] link_offset = '0;
  logic [1:0] rd_link;
  logic [4:0] rd_slot;
  logic [7:0] rd_byte;
  logic [3:0] rd_sig;
  logic ser_data, ser_sig, offset_clash, fp_period_err, irq;

  logic [7:0] mem_b [4][32];
  logic [3:0] mem_s [4][32];
  assign rd_byte = mem_b[rd_link][rd_slot];
  assign rd_sig  = mem_s[rd_link][rd_slot];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bmux_quad dut_i (
    .clk, .rst_n, .bclk, .fp_in, .fp_active_low, .fp_fall, .data_fall,
    .clk2x, .second_edge, .bit_offset, .link_offset, .irq_en,
    .rd_link, .rd_slot, .rd_byte, .rd_sig,
    .ser_data, .ser_sig, .offset_clash, .fp_period_err, .irq
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int owner_of(int r);
    for (int l = 0; l < 4; l++)
      if (int'(link_offset[2*l +: 2]) == r) return l;
    return -1;
  endfunction

  function automatic bit clash_exp();
    for (int a = 0; a < 4; a++)
      for (int b = a + 1; b < 4; b++)
        if (link_offset[2*a +: 2] == link_offset[2*b +: 2]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic run(input bit x2, input bit sec, input bit ff, input bit df,
                     input bit low, input int boff, input logic [7:0] offs,
                     input bit en, input int extra, input string tag);
    int per, p1, p2, total, j, b, s, bt, l;
    bit pend, defer, half, locked, h, tick, newv, de, fe, act, ed, es, pd, ps;
    per = x2 ? 4096 : 2048;
    rst_n = 1'b0;
    bclk = 1'b0;
    fp_in = low;
    clk2x = x2; second_edge = sec; fp_fall = ff; data_fall = df;
    fp_active_low = low; bit_offset = 10'(boff); link_offset = offs; irq_en = en;
    for (int a = 0; a < 4; a++)
      for (int t = 0; t < 32; t++) begin
        mem_b[a][t] = 8'($urandom);
        mem_s[a][t] = 4'($urandom);
      end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #2;
    chk(ser_data === 1'b1, {"R11 reset ser_data ", tag}, ser_data, 1);
    chk(ser_sig === 1'b1, {"R11 reset ser_sig ", tag}, ser_sig, 1);
    chk(fp_period_err === 1'b0, {"R11 reset err ", tag}, fp_period_err, 0);
    chk(irq === 1'b0, {"R11 reset irq ", tag}, irq, 0);
    chk(offset_clash === clash_exp(), {"R2 clash flag ", tag}, offset_clash, clash_exp());
    // step n drives bclk to 1 when n is even
    p1 = 6;
    if ((ff ? 0 : 1) != ((p1 % 2 == 0) ? 1 : 0)) p1++;
    p2 = p1 + per + extra;
    total = p2 + 700;
    pend = 0; defer = 0; half = 0; locked = 0; j = 0;
    pd = 1; ps = 1;
    for (int n = 0; n < total; n++) begin
      @(negedge clk);
      bclk = ~bclk;
      act = (n == p1) || (n == p1 + 1) || (n == p2) || (n == p2 + 1);
      fp_in = act ^ low;
      @(posedge clk); #2;
      newv = bclk;
      de = df ? !newv : newv;
      fe = ff ? !newv : newv;
      tick = 0;
      if (de) begin
        h = pend ? 1'b0 : half;
        half = !h;
        tick = !x2 || (h == sec);
        if (tick) begin
          if (pend || defer) begin
            j = 0; locked = 1; defer = 0;
          end else j = (j + 1) % FB;
        end else if (pend) defer = 1;
        pend = 0;
      end
      if (fe && (n == p1 || n == p2)) pend = 1;
      if (!locked) begin
        chk(ser_data === 1'b1 && ser_sig === 1'b1, {"R9 idle ones ", tag},
            {ser_data, ser_sig}, 3);
      end else if (tick) begin
        b = (j - boff + FB) % FB;
        s = b / 8; bt = b % 8;
        l = owner_of(s % 4);
        if (l < 0) begin
          ed = 1; es = 1;
        end else begin
          ed = mem_b[l][s / 4][7 - bt];
          es = (bt < 4) ? 1'b1 : mem_s[l][s / 4][7 - bt];
        end
        chk(ser_data === ed, {(l < 0) ? "R3" : (clash_exp() ? "R2" : "R1"),
            " data ", tag}, ser_data, ed);
        chk(ser_sig === es, {"R4 sig ", tag}, ser_sig, es);
      end else begin
        chk(ser_data === pd && ser_sig === ps, {"R9 hold ", tag},
            {ser_data, ser_sig}, {pd, ps});
      end
      pd = ser_data; ps = ser_sig;
      if (n == p2 - 1)
        chk(fp_period_err === 1'b0, {"R10 no early err ", tag}, fp_period_err, 0);
    end
    chk(fp_period_err === (extra != 0), {"R10 period err ", tag},
        fp_period_err, int'(extra != 0));
    chk(irq === ((extra != 0) && en), {"R10 irq ", tag}, irq, int'((extra != 0) && en));
  endtask

  initial begin
    logic [7:0] perm;
    int seed;
    seed = $urandom(32'h5EED_0042);
    perm = {2'd0, 2'd1, 2'd2, 2'd3} ^ {4{2'($urandom)}};
    // R1 R5 R6: rising edges, active-high pulse, random distinct offsets
    run(0, 0, 0, 0, 0, int'($urandom % 1024), perm, 1, 0, "R1 R6 base");
    // R5 R8: active-low pulse, falling sample edge, bit offset 5
    run(0, 0, 1, 0, 1, 5, 8'b10_01_00_11, 1, 0, "R5 R8 low");
    // R7 R2 R3: double rate first edge, clashing offsets, residue 3 unowned
    run(1, 0, 0, 1, 0, 1023, 8'b00_10_01_01, 0, 0, "R7 first");
    // R7 R2: double rate second edge, all offsets equal, same edges
    run(1, 1, 1, 1, 0, 37, 8'b10_10_10_10, 0, 0, "R7 second");
    // R10: bad pulse spacing with and without irq enable
    run(0, 0, 0, 0, 0, 0, 8'b11_10_01_00, 1, 2, "R10 irq on");
    run(0, 0, 1, 1, 1, 200, 8'b00_01_10_11, 0, 2, "R10 irq off");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule